// File: doc/BRIEF.md
# Interrupt Pin Pending and End-of-Interrupt Conditioner

This block sits at the input side of an interrupt routing controller. Each interrupt pin has a routing entry that gives its polarity, its trigger mode (edge or level), a mask bit and a vector number. The block turns the raw pin levels into a pending vector and picks pins that need delivery. It presents them one at a time on a request/acknowledge handshake towards the delivery stage.

Level-triggered pins use a remote-pending flag. A successful delivery sets it. While it is set, the pin is not requested again. An end-of-interrupt message carrying a vector number clears the flag on every pin routed to that vector. A pin that is still asserted and unmasked is then requested again. Edge-triggered pins are requested once per rising edge of their effective level, and their pending bit is consumed when the delivery stage acknowledges. Destination resolution happens downstream and is not part of this block.

Top module: `irq_pend_eoi`

## Requirements
- R1: After reset, `svc_valid` is 0 and every bit of `pend_o` and `rirr_o` is 0.
- R2: The effective level of pin i is `pin_raw[i] ^ ent_pol[i]`. For a level-triggered pin (`ent_lvl[i]`=1), `pend_o[i]` equals the effective level sampled at the previous clock edge.
- R3: For an edge-triggered pin (`ent_lvl[i]`=0), `pend_o[i]` becomes 1 at the edge where the unmasked effective level is 1 and was 0 at the edge before. It becomes 0 when the effective level is 0. A level that stays high does not set it again.
- R4: A masked pin (`ent_mask[i]`=1) is never requested. A masked edge-triggered pin ignores rising edges and has any pending bit cleared.
- R5: When no request is open and at least one pin is eligible, a request opens on the next edge for the lowest-numbered eligible pin. A pin is eligible if it is pending and unmasked, and, for a level-triggered pin, its remote flag is clear. `svc_pin` and `svc_vector` (the pin's `ent_vec` field, bits i*VEC_W upward) are held until `dlv_ack`.
- R6: An acknowledge for an edge-triggered pin clears its pending bit, unless a new unmasked rising edge arrives at the same edge.
- R7: An acknowledge with `dlv_ok`=1 for a level-triggered pin sets its remote flag, and the pin is not requested again while the flag is set. An acknowledge with `dlv_ok`=0 leaves the flag clear, so the pin is requested again.
- R8: An `eoi_valid` pulse clears the remote flag of every pin whose `ent_vec` equals `eoi_vec`, and the pin is requested again if it is still pending and unmasked. A same-edge successful acknowledge on a level pin takes precedence over the clear.
- R9: The cycle after an acknowledge always has `svc_valid`=0. The next request can open one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | NUM_PINS | Synchronized raw pin levels |
| ent_pol | input | NUM_PINS | Per-pin polarity, 1 = active low |
| ent_lvl | input | NUM_PINS | Per-pin trigger mode, 1 = level |
| ent_mask | input | NUM_PINS | Per-pin mask |
| ent_vec | input | NUM_PINS*VEC_W | Per-pin vector, pin i at bits i*VEC_W upward |
| dlv_ack | input | 1 | Delivery stage accepts the open request |
| dlv_ok | input | 1 | With dlv_ack: delivery reached a target |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | VEC_W | Vector carried by the end-of-interrupt |
| svc_valid | output | 1 | A service request is open |
| svc_pin | output | PIN_W | Pin being serviced |
| svc_vector | output | VEC_W | Vector of the pin being serviced |
| pend_o | output | NUM_PINS | Pending vector |
| rirr_o | output | NUM_PINS | Remote-pending flags |

## Verification
The assertions assume a few things about the inputs. The pin inputs are already synchronized. `dlv_ack` only has meaning while a request is open. A pin's routing entry is treated as sampled at each edge, with no ordering against the handshake. The stimulus keeps to this by changing every input only a fraction of a cycle after the rising edge. It also fixes the vectors so that several pins share one vector. In the random phase, acknowledges and end-of-interrupts arrive at arbitrary cycles, including while the block is idle, where the acknowledge must have no effect.

// File: rtl/irq_pend_eoi_pkg.sv
package irq_pend_eoi_pkg;
   typedef enum logic {
      SVC_IDLE = 1'b0,
      SVC_BUSY = 1'b1
   } svc_state_e;
endpackage

// File: rtl/irq_pin_cell.sv
module irq_pin_cell #(
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raw,
   input  logic             pol,
   input  logic             lvl_trig,
   input  logic             mask,
   input  logic [VEC_W-1:0] vec,
   input  logic             eoi_valid,
   input  logic [VEC_W-1:0] eoi_vec,
   input  logic             done,
   input  logic             ok,
   output logic             pend,
   output logic             rirr,
   output logic             want
);
   logic eff, eff_q, rise, eoi_hit, set_r;

   always_comb begin
      eff     = raw ^ pol;
      rise    = eff & ~eff_q;
      eoi_hit = eoi_valid && (vec == eoi_vec);
      set_r   = done & ok & lvl_trig;
      want    = pend & ~mask & (~lvl_trig | ~rirr);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eff_q <= 1'b0;
         pend  <= 1'b0;
         rirr  <= 1'b0;
      end else begin
         eff_q <= eff;
         if (lvl_trig)            pend <= eff;
         else if (!eff)           pend <= 1'b0;
         else if (rise && !mask)  pend <= 1'b1;
         else if (mask || done)   pend <= 1'b0;
         if (set_r)               rirr <= 1'b1;
         else if (eoi_hit)        rirr <= 1'b0;
      end
   end

   AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_trig |=> (pend == $past(eff)));                                  // R2
   AST_EDGE_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !mask && !lvl_trig) |=> pend);                              // R3
   AST_MASKED_EDGE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mask && !lvl_trig) |=> !pend);                                      // R4
   AST_EDGE_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !lvl_trig && !(rise && !mask)) |=> !pend);                  // R6
   AST_RIRR_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      set_r |=> rirr);                                                     // R7
   AST_EOI_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_hit && !set_r) |=> !rirr);                                      // R8
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
   parameter int NUM_PINS = 8,
   parameter int PIN_W    = $clog2(NUM_PINS)
) (
   input  logic [NUM_PINS-1:0] req,
   output logic                any,
   output logic [PIN_W-1:0]    idx
);
   always_comb begin
      any = |req;
      idx = '0;
      for (int i = NUM_PINS - 1; i >= 0; i--) begin
         if (req[i]) idx = PIN_W'(i);
      end
   end

   always_comb begin
      if (any) begin
         AST_PICK_IS_REQ: assert (req[idx]);                                              // R5
         AST_PICK_LOWEST: assert ((req & ((NUM_PINS'(1) << idx) - NUM_PINS'(1))) == '0);  // R5
      end
   end
endmodule

// File: rtl/irq_pend_eoi.sv
module irq_pend_eoi
   import irq_pend_eoi_pkg::*;
#(
   parameter int NUM_PINS = 8,
   parameter int VEC_W    = 8,
   parameter int PIN_W    = $clog2(NUM_PINS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_PINS-1:0]       pin_raw,
   input  logic [NUM_PINS-1:0]       ent_pol,
   input  logic [NUM_PINS-1:0]       ent_lvl,
   input  logic [NUM_PINS-1:0]       ent_mask,
   input  logic [NUM_PINS*VEC_W-1:0] ent_vec,
   input  logic                      dlv_ack,
   input  logic                      dlv_ok,
   input  logic                      eoi_valid,
   input  logic [VEC_W-1:0]          eoi_vec,
   output logic                      svc_valid,
   output logic [PIN_W-1:0]          svc_pin,
   output logic [VEC_W-1:0]          svc_vector,
   output logic [NUM_PINS-1:0]       pend_o,
   output logic [NUM_PINS-1:0]       rirr_o
);
   localparam int TBL_W = NUM_PINS * VEC_W;

   if (NUM_PINS < 2 || NUM_PINS > 64) begin : g_bad_pins
      $error("irq_pend_eoi: NUM_PINS must lie in 2..64");
   end
   if (VEC_W < 1 || TBL_W < 1) begin : g_bad_vec
      $error("irq_pend_eoi: VEC_W must be at least 1");
   end

   svc_state_e             state_q;
   logic [PIN_W-1:0]       cur_q;
   logic [NUM_PINS-1:0]    want, done;
   logic                   pick_any;
   logic [PIN_W-1:0]       pick_idx;

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
      assign done[g] = (state_q == SVC_BUSY) && dlv_ack && (cur_q == PIN_W'(g));
      irq_pin_cell #(.VEC_W(VEC_W)) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .raw       (pin_raw[g]),
         .pol       (ent_pol[g]),
         .lvl_trig  (ent_lvl[g]),
         .mask      (ent_mask[g]),
         .vec       (ent_vec[g*VEC_W +: VEC_W]),
         .eoi_valid (eoi_valid),
         .eoi_vec   (eoi_vec),
         .done      (done[g]),
         .ok        (dlv_ok),
         .pend      (pend_o[g]),
         .rirr      (rirr_o[g]),
         .want      (want[g])
      );
   end

   irq_lowest_pick #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_pick (
      .req (want),
      .any (pick_any),
      .idx (pick_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SVC_IDLE;
         cur_q   <= '0;
      end else if (state_q == SVC_IDLE) begin
         if (pick_any) begin
            state_q <= SVC_BUSY;
            cur_q   <= pick_idx;
         end
      end else if (dlv_ack) begin
         state_q <= SVC_IDLE;
      end
   end

   always_comb begin
      svc_valid  = (state_q == SVC_BUSY);
      svc_pin    = cur_q;
      svc_vector = '0;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (cur_q == PIN_W'(i)) svc_vector = ent_vec[i*VEC_W +: VEC_W];
      end
   end

   AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_valid && !dlv_ack) |=> (svc_valid && $stable(svc_pin)));        // R5
   AST_GRANT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (!svc_valid && pick_any) |=> (svc_valid && svc_pin == $past(pick_idx))); // R5
   AST_GAP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_valid && dlv_ack) |=> !svc_valid);                              // R9
   AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(done));                                                     // R5
endmodule

// File: tb/tb_irq_pend_eoi.sv
module tb_irq_pend_eoi;
   localparam int N  = 8;
   localparam int VW = 8;
   localparam int PW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0]    pin_raw = '0, ent_pol = '0, ent_lvl = '0, ent_mask = '1;
   logic [N*VW-1:0] ent_vec;
   logic dlv_ack = 1'b0, dlv_ok = 1'b0, eoi_valid = 1'b0;
   logic [VW-1:0]   eoi_vec = '0;
   logic            svc_valid;
   logic [PW-1:0]   svc_pin;
   logic [VW-1:0]   svc_vector;
   logic [N-1:0]    pend_o, rirr_o;

   int tests = 0, fails = 0;

   always #4 clk = ~clk;

   irq_pend_eoi #(.NUM_PINS(N), .VEC_W(VW)) dut (
      .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .ent_pol(ent_pol),
      .ent_lvl(ent_lvl), .ent_mask(ent_mask), .ent_vec(ent_vec),
      .dlv_ack(dlv_ack), .dlv_ok(dlv_ok), .eoi_valid(eoi_valid),
      .eoi_vec(eoi_vec), .svc_valid(svc_valid), .svc_pin(svc_pin),
      .svc_vector(svc_vector), .pend_o(pend_o), .rirr_o(rirr_o));

   // behavioural reference model
   bit m_pend[N], m_rirr[N], m_prev[N];
   bit m_busy;
   int m_cur;

   function automatic int vec_of(int p);
      return int'(ent_vec[p*VW +: VW]);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_pend[i]) begin m_pend[i] = 0; m_rirr[i] = 0; m_prev[i] = 0; end
         m_busy = 0; m_cur = 0;
      end else begin
         bit o_pend[N], o_rirr[N];
         bit o_busy;
         int o_cur;
         o_pend = m_pend; o_rirr = m_rirr; o_busy = m_busy; o_cur = m_cur;
         foreach (m_pend[i]) begin
            bit lvl, fin;
            lvl = pin_raw[i] ^ ent_pol[i];
            fin = o_busy && dlv_ack && (o_cur == i);
            if (ent_lvl[i]) m_pend[i] = lvl;
            else if (lvl == 0) m_pend[i] = 0;
            else if (!m_prev[i] && !ent_mask[i]) m_pend[i] = 1;
            else if (ent_mask[i] || fin) m_pend[i] = 0;
            if (fin && dlv_ok && ent_lvl[i]) m_rirr[i] = 1;
            else if (eoi_valid && vec_of(i) == int'(eoi_vec)) m_rirr[i] = 0;
            m_prev[i] = lvl;
         end
         if (o_busy) begin
            if (dlv_ack) m_busy = 0;
         end else begin
            for (int i = 0; i < N; i++) begin
               if (o_pend[i] && !ent_mask[i] && (!ent_lvl[i] || !o_rirr[i])) begin
                  m_busy = 1; m_cur = i; break;
               end
            end
         end
      end
   end

   task automatic chk(string what, int act, int exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   function automatic int packv(bit a[N]);
      int r = 0;
      for (int i = 0; i < N; i++) if (a[i]) r |= (1 << i);
      return r;
   endfunction

   task automatic cyc();
      @(posedge clk);
      #2;
      if (rst_n) begin
         chk("R5 model svc_valid", int'(svc_valid), int'(m_busy));
         if (m_busy) begin
            chk("R5 model svc_pin", int'(svc_pin), m_cur);
            chk("R5 model svc_vector", int'(svc_vector), vec_of(m_cur));
         end
         chk("R2 R3 model pend", int'(pend_o), packv(m_pend));
         chk("R7 R8 model rirr", int'(rirr_o), packv(m_rirr));
      end
   endtask

   task automatic cycn(int n);
      for (int k = 0; k < n; k++) cyc();
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) ent_vec[i*VW +: VW] = VW'(8'h10 * (1 + i % 4));
      cycn(2);
      rst_n = 1'b1;
      cyc();
      chk("R1 reset svc_valid", int'(svc_valid), 0);
      chk("R1 reset pend", int'(pend_o), 0);
      chk("R1 reset rirr", int'(rirr_o), 0);

      // level pin 3, vector 0x40
      ent_lvl[3] = 1; ent_mask[3] = 0; pin_raw[3] = 1;
      cyc();
      chk("R2 level pend set", int'(pend_o[3]), 1);
      cyc();
      chk("R5 request opens", int'(svc_valid), 1);
      chk("R5 request pin", int'(svc_pin), 3);
      chk("R5 request vector", int'(svc_vector), 'h40);
      cycn(2);
      chk("R5 held without ack", int'(svc_valid && svc_pin == 3), 1);
      dlv_ack = 1; dlv_ok = 1;
      cyc();
      dlv_ack = 0;
      chk("R7 remote flag set", int'(rirr_o[3]), 1);
      cycn(3);
      chk("R7 no repeat while flagged", int'(svc_valid), 0);
      eoi_valid = 1; eoi_vec = 8'h40;
      cyc();
      eoi_valid = 0;
      chk("R8 eoi clears flag", int'(rirr_o[3]), 0);
      cyc();
      chk("R8 re-request after eoi", int'(svc_valid && svc_pin == 3), 1);
      dlv_ack = 1; dlv_ok = 0;
      cyc();
      dlv_ack = 0;
      chk("R7 failed delivery leaves flag", int'(rirr_o[3]), 0);
      cyc();
      chk("R7 failed delivery retried", int'(svc_valid && svc_pin == 3), 1);
      dlv_ack = 1; dlv_ok = 1;
      cyc();
      dlv_ack = 0; pin_raw[3] = 0;
      cyc();
      chk("R2 level pend drops", int'(pend_o[3]), 0);
      eoi_valid = 1;
      cyc();
      eoi_valid = 0;

      // polarity on masked level pin 5
      ent_lvl[5] = 1; ent_pol[5] = 1; pin_raw[5] = 1;
      cyc();
      chk("R2 inverted high is idle", int'(pend_o[5]), 0);
      pin_raw[5] = 0;
      cyc();
      chk("R2 inverted low is active", int'(pend_o[5]), 1);
      chk("R4 masked not requested", int'(svc_valid), 0);
      ent_pol[5] = 0;
      cyc();

      // edge pins 1 and 2 together
      ent_mask[2:1] = 2'b00; pin_raw[2:1] = 2'b11;
      cyc();
      chk("R3 edge pend set", int'(pend_o[2:1]), 3);
      cyc();
      chk("R5 lowest pin first", int'(svc_valid && svc_pin == 1), 1);
      dlv_ack = 1; dlv_ok = 1;
      cyc();
      dlv_ack = 0;
      chk("R6 ack clears edge pend", int'(pend_o[2:1]), 2);
      chk("R7 edge sets no flag", int'(rirr_o[1]), 0);
      chk("R9 gap after ack", int'(svc_valid), 0);
      cyc();
      chk("R9 next pin after gap", int'(svc_valid && svc_pin == 2), 1);
      dlv_ack = 1;
      cyc();
      dlv_ack = 0;
      cycn(3);
      chk("R3 steady high no retrigger", int'(svc_valid || pend_o[2:1] != 0), 0);
      pin_raw[1] = 0;
      cyc();
      pin_raw[1] = 1;
      cyc();
      chk("R3 new rising edge", int'(pend_o[1]), 1);
      cyc();
      dlv_ack = 1;
      cyc();
      dlv_ack = 0;

      // masked edge pin 4
      ent_mask[4] = 1; pin_raw[4] = 1;
      cyc();
      chk("R4 masked edge ignored", int'(pend_o[4]), 0);
      cycn(2);
      chk("R4 masked edge no request", int'(svc_valid), 0);
      ent_mask[4] = 0;
      cyc();
      chk("R3 unmask while high no edge", int'(pend_o[4]), 0);

      // shared vector 0x10 on pins 0 and 4
      ent_lvl[0] = 1; ent_lvl[4] = 1; ent_mask[0] = 0; pin_raw[0] = 1;
      cycn(2);
      chk("R5 pin 0 first", int'(svc_valid && svc_pin == 0), 1);
      dlv_ack = 1; dlv_ok = 1;
      cyc();
      dlv_ack = 0;
      cyc();
      chk("R5 pin 4 next", int'(svc_valid && svc_pin == 4), 1);
      dlv_ack = 1;
      cyc();
      dlv_ack = 0;
      chk("R7 both flagged", int'(rirr_o & 8'h11), 'h11);
      eoi_valid = 1; eoi_vec = 8'h10;
      cyc();
      eoi_valid = 0;
      chk("R8 eoi clears both", int'(rirr_o & 8'h11), 0);

      // random phase, compared with the model every cycle
      for (int k = 0; k < 4000; k++) begin
         if ($urandom % 3 == 0) pin_raw[$urandom % N] ^= 1'b1;
         if ($urandom % 40 == 0) ent_mask[$urandom % N] ^= 1'b1;
         if ($urandom % 60 == 0) ent_lvl[$urandom % N] ^= 1'b1;
         if ($urandom % 80 == 0) ent_pol[$urandom % N] ^= 1'b1;
         dlv_ack   = ($urandom % 3 == 0);
         dlv_ok    = ($urandom % 4 != 0);
         eoi_valid = ($urandom % 5 == 0);
         eoi_vec   = VW'(8'h10 * (1 + $urandom % 4));
         cyc();
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule